// File: doc/BRIEF.md
# Receive Buffer Space Accounting Unit

This unit keeps track of how much room is left in a receive buffer that the host sets aside in memory for a small network interface. The host programs the buffer through a simple register bus: a base address, a size in 32-bit words, a reception enable bit and an accepted-class mask. After it has consumed packets, the host returns the space by writing to a space-return register. This register adds to the free-space count rather than overwriting it.

The receive path offers each stored packet on a valid/ready stream. Each offer carries the packet length in words and the address of its descriptor. When the host has not enabled reception, `pkt_ready` stays low and the offer is held, which is back-pressure. Once enabled, every offer is taken in the same cycle. An offer is committed only if its length plus a fixed descriptor overhead fits in the free space. A committed offer lowers the count, advances a wrapping write pointer and records its descriptor address. An offer that does not fit is taken and discarded, and a one-cycle drop pulse is raised. A flag reports whether the buffer holds unconsumed packets. Reading the address register returns the last committed descriptor address, not the base that was written.

Top module: `rx_space_acct`

## Requirements
- R1: After reset the enable bit, class mask, size, free-space count, base, write pointer, has-packet flag and drop pulse are all zero.
- R2: Register 0 (control) holds the enable bit at bit 0 and the class mask at bits 23:16, both writable. Bit 8 is the read-only has-packet flag and is 1 when the buffer holds at least one packet. The `rx_enable` and `class_mask` pins show the stored values.
- R3: A write to register 2 (size) sets the buffer size and reloads the free-space count to that size. It also returns the write pointer to the base and clears the has-packet flag. Reading register 2 returns the size.
- R4: A write to register 1 (address) sets the buffer base and moves the write pointer to it. Reading register 1 returns the descriptor address of the most recently committed packet.
- R5: A write to register 3 (space return) adds the written value to the free-space count, saturating at the buffer size. Reading register 3 returns the free-space count. Register reads are combinational on `host_addr`.
- R6: `pkt_ready` equals the enable bit. While it is 0, an offered packet is held and the count, the pointer and the flag do not change.
- R7: A taken packet with length + DESC_WORDS <= free count is committed. The count drops by length + DESC_WORDS, the has-packet flag sets, and its descriptor address is recorded. The boundary case of an exact fit is included.
- R8: A taken packet with length + DESC_WORDS > free count is discarded. `pkt_drop` is high for exactly the next cycle, and the count and pointer are unchanged.
- R9: A space return and a commit in the same cycle are both applied, as count + returned - charge.
- R10: A space return that brings the count back to the full size clears the has-packet flag.
- R11: The write pointer advances by length + DESC_WORDS on each commit and wraps by the size, so it stays within [base, base + size).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 2 | Register select |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data (combinational) |
| pkt_valid | input | 1 | Packet report offered |
| pkt_ready | output | 1 | Packet report taken |
| pkt_words | input | LW | Packet length in 32-bit words |
| pkt_desc_addr | input | AW | Descriptor address of the packet |
| pkt_drop | output | 1 | One-cycle pulse after a discarded packet |
| wr_ptr | output | AW | Address where the next packet is to be written |
| rx_enable | output | 1 | Reception enable bit |
| class_mask | output | 8 | Accepted-class mask |
| rx_has_pkt | output | 1 | Buffer holds at least one packet |

## Verification
The stream is driven in five ways. Packets that fit show the decrement and the pointer advance. An oversized packet shows that a drop leaves the state untouched. An exact fit separates the <= fit test from <. A packet that lands on the buffer end shows the wrap. Offers while disabled show that back-pressure holds rather than drops. Space returns are tried on their own, in the same cycle as a commit, up to the full size and beyond it. Together these tell additive return apart from overwrite, joint update apart from one update winning, flag clearing, and saturation.

// File: rtl/rx_space_pkg.sv
package rx_space_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_ADDR  = 2'd1,
    REG_SIZE  = 2'd2,
    REG_AVAIL = 2'd3
  } reg_sel_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_HAS_BIT  = 8;
  localparam int CTRL_MASK_LSB = 16;
  localparam int MASK_W        = 8;
endpackage

// File: rtl/rx_space_regs.sv
module rx_space_regs
  import rx_space_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [1:0]        host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              has_pkt,
  input  logic [AW-1:0]     last_desc,
  input  logic [AW-1:0]     avail,
  input  logic [AW-1:0]     size_q,
  output logic              enable_o,
  output logic [MASK_W-1:0] mask_o,
  output logic [AW-1:0]     base_o,
  output logic              base_ld_o,
  output logic              size_ld_o,
  output logic              ret_en_o,
  output logic [AW-1:0]     wval_o
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(host_addr);

  assign base_ld_o = host_we && (sel == REG_ADDR);
  assign size_ld_o = host_we && (sel == REG_SIZE);
  assign ret_en_o  = host_we && (sel == REG_AVAIL);
  assign wval_o    = host_wdata[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_o <= 1'b0;
      mask_o   <= '0;
      base_o   <= '0;
    end else begin
      if (host_we && sel == REG_CTRL) begin
        enable_o <= host_wdata[CTRL_EN_BIT];
        mask_o   <= host_wdata[CTRL_MASK_LSB +: MASK_W];
      end
      if (base_ld_o) base_o <= wval_o;
    end
  end

  always_comb begin
    host_rdata = '0;
    unique case (sel)
      REG_CTRL: begin
        host_rdata[CTRL_EN_BIT]              = enable_o;
        host_rdata[CTRL_HAS_BIT]             = has_pkt;
        host_rdata[CTRL_MASK_LSB +: MASK_W]  = mask_o;
      end
      REG_ADDR:  host_rdata[AW-1:0] = last_desc;
      REG_SIZE:  host_rdata[AW-1:0] = size_q;
      REG_AVAIL: host_rdata[AW-1:0] = avail;
      default:   host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rx_space_ledger.sv
module rx_space_ledger #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          size_ld,
  input  logic          ret_en,
  input  logic [AW-1:0] wval,
  input  logic          commit,
  input  logic [AW:0]   charge,
  output logic          fit,
  output logic [AW-1:0] avail_q,
  output logic [AW-1:0] size_q,
  output logic          has_pkt_q
);
  localparam int SW = AW + 2;

  logic [SW-1:0] sum;
  logic [SW-1:0] ret_ext;
  logic [SW-1:0] chg_ext;
  logic [AW-1:0] sat;

  assign fit     = ({1'b0, avail_q} >= charge);
  assign ret_ext = ret_en ? SW'(wval) : '0;
  assign chg_ext = commit ? SW'(charge) : '0;
  assign sum     = SW'(avail_q) + ret_ext - chg_ext;
  assign sat     = (sum > SW'(size_q)) ? size_q : sum[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avail_q   <= '0;
      size_q    <= '0;
      has_pkt_q <= 1'b0;
    end else if (size_ld) begin
      size_q    <= wval;
      avail_q   <= wval;
      has_pkt_q <= 1'b0;
    end else begin
      avail_q <= sat;
      if (commit)                       has_pkt_q <= 1'b1;
      else if (ret_en && sat == size_q) has_pkt_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_space_wptr.sv
module rx_space_wptr #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload,
  input  logic [AW-1:0] reload_val,
  input  logic          commit,
  input  logic [AW:0]   charge,
  input  logic [AW-1:0] base_q,
  input  logic [AW-1:0] size_q,
  output logic [AW-1:0] ptr_q
);
  logic [AW:0] nxt;
  logic [AW:0] lim;
  logic [AW:0] wrapped;

  assign nxt     = {1'b0, ptr_q} + charge;
  assign lim     = {1'b0, base_q} + {1'b0, size_q};
  assign wrapped = (nxt >= lim) ? (nxt - {1'b0, size_q}) : nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (reload)  ptr_q <= reload_val;
    else if (commit)  ptr_q <= wrapped[AW-1:0];
  end
endmodule

// File: rtl/rx_space_acct.sv
module rx_space_acct
  import rx_space_pkg::*;
#(
  parameter int AW         = 24,
  parameter int LW         = 16,
  parameter int DESC_WORDS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [1:0]    host_addr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  input  logic          pkt_valid,
  output logic          pkt_ready,
  input  logic [LW-1:0] pkt_words,
  input  logic [AW-1:0] pkt_desc_addr,
  output logic          pkt_drop,
  output logic [AW-1:0] wr_ptr,
  output logic          rx_enable,
  output logic [7:0]    class_mask,
  output logic          rx_has_pkt
);
  logic          base_ld, size_ld, ret_en, fit, hs, commit_w;
  logic [AW-1:0] wval, base_q, size_q, avail_q, last_desc_q;
  logic [AW:0]   charge;

  assign charge    = (AW+1)'(pkt_words) + (AW+1)'(DESC_WORDS);
  assign pkt_ready = rx_enable;
  assign hs        = pkt_valid && pkt_ready;
  assign commit_w  = hs && fit && !size_ld;

  rx_space_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .has_pkt(rx_has_pkt),
    .last_desc(last_desc_q), .avail(avail_q), .size_q(size_q),
    .enable_o(rx_enable), .mask_o(class_mask), .base_o(base_q),
    .base_ld_o(base_ld), .size_ld_o(size_ld), .ret_en_o(ret_en), .wval_o(wval)
  );

  rx_space_ledger #(.AW(AW)) u_ledger (
    .clk(clk), .rst_n(rst_n), .size_ld(size_ld), .ret_en(ret_en), .wval(wval),
    .commit(commit_w), .charge(charge), .fit(fit), .avail_q(avail_q),
    .size_q(size_q), .has_pkt_q(rx_has_pkt)
  );

  rx_space_wptr #(.AW(AW)) u_wptr (
    .clk(clk), .rst_n(rst_n), .reload(base_ld || size_ld),
    .reload_val(base_ld ? wval : base_q), .commit(commit_w), .charge(charge),
    .base_q(base_q), .size_q(size_q), .ptr_q(wr_ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_drop    <= 1'b0;
      last_desc_q <= '0;
    end else begin
      pkt_drop <= hs && !fit;
      if (commit_w) last_desc_q <= pkt_desc_addr;
    end
  end
endmodule

// File: rtl/rx_space_acct_chk.sv
module rx_space_acct_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_we,
  input logic [1:0]    host_addr,
  input logic [31:0]   host_wdata,
  input logic          pkt_valid,
  input logic          pkt_ready,
  input logic          pkt_drop,
  input logic          rx_has_pkt,
  input logic          commit_w,
  input logic [AW-1:0] pkt_desc_addr,
  input logic [AW-1:0] last_desc_q,
  input logic [AW-1:0] avail_q,
  input logic [AW-1:0] size_q,
  input logic [AW-1:0] base_q,
  input logic [AW-1:0] wr_ptr
);
  assert_size_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == 2'd2) |=> (avail_q == $past(host_wdata[AW-1:0])));

  assert_avail_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    avail_q <= size_q);

  assert_commit_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_w |=> (rx_has_pkt && last_desc_q == $past(pkt_desc_addr)));

  assert_drop_after_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_drop |-> $past(pkt_valid && pkt_ready));

  assert_drop_keeps_avail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_drop && !$past(host_we)) |-> $stable(avail_q));

  assert_ptr_in_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (size_q != '0) |-> ({1'b0, wr_ptr} >= {1'b0, base_q} &&
                        {1'b0, wr_ptr} < ({1'b0, base_q} + {1'b0, size_q})));
endmodule

bind rx_space_acct rx_space_acct_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
  .host_wdata(host_wdata), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
  .pkt_drop(pkt_drop), .rx_has_pkt(rx_has_pkt), .commit_w(commit_w),
  .pkt_desc_addr(pkt_desc_addr), .last_desc_q(last_desc_q), .avail_q(avail_q),
  .size_q(size_q), .base_q(base_q), .wr_ptr(wr_ptr)
);

// File: tb/rx_space_acct_bench.sv
module rx_space_acct_bench;
  localparam int AW = 24;
  localparam int LW = 16;
  localparam int DW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_we = 1'b0;
  logic [1:0]    host_addr = 2'd3;
  logic [31:0]   host_wdata = '0;
  logic [31:0]   host_rdata;
  logic          pkt_valid = 1'b0;
  logic          pkt_ready;
  logic [LW-1:0] pkt_words = '0;
  logic [AW-1:0] pkt_desc_addr = '0;
  logic          pkt_drop;
  logic [AW-1:0] wr_ptr;
  logic          rx_enable;
  logic [7:0]    class_mask;
  logic          rx_has_pkt;

  rx_space_acct #(.AW(AW), .LW(LW), .DESC_WORDS(DW)) u_rx_space_acct (.*);

  always #5 clk = ~clk;

  typedef struct packed {
    logic          drop;
    logic          has;
    logic [AW-1:0] avail;
    logic [AW-1:0] ptr;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int failures = 0;
  logic hs_seen = 1'b0;

  int m_avail = 0, m_size = 0, m_base = 0, m_ptr = 0, m_last = 0;
  logic m_has = 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic host_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0; host_addr = 2'd3;
  endtask

  task automatic host_read(string req, logic [1:0] a, logic [31:0] expv);
    @(negedge clk);
    host_addr = a;
    #1;
    check(req, host_rdata, expv);
    host_addr = 2'd3;
  endtask

  // Driver: offers one packet (optionally with a space return) and predicts the result.
  task automatic send_pkt(int len, int ret);
    exp_t e;
    int ch, sum;
    logic fits;
    @(negedge clk);
    pkt_valid = 1'b1; pkt_words = LW'(len); pkt_desc_addr = AW'(m_ptr);
    if (ret > 0) begin host_we = 1'b1; host_addr = 2'd3; host_wdata = 32'(ret); end
    ch = len + DW;
    fits = (ch <= m_avail);
    sum = m_avail + ret - (fits ? ch : 0);
    if (sum > m_size) sum = m_size;
    if (fits) begin
      m_has = 1'b1; m_last = m_ptr;
      m_ptr = m_ptr + ch;
      if (m_ptr >= m_base + m_size) m_ptr = m_ptr - m_size;
    end else if (ret > 0 && sum == m_size) m_has = 1'b0;
    m_avail = sum;
    e.drop = !fits; e.has = m_has; e.avail = AW'(m_avail); e.ptr = AW'(m_ptr);
    exp_q.push_back(e);
    @(negedge clk);
    pkt_valid = 1'b0; host_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic host_return(int ret);
    int sum;
    sum = m_avail + ret;
    if (sum > m_size) sum = m_size;
    if (sum == m_size) m_has = 1'b0;
    m_avail = sum;
    host_write(2'd3, 32'(ret));
  endtask

  always @(posedge clk) hs_seen <= pkt_valid && pkt_ready;

  // Monitor: compares each packet outcome one cycle after the handshake.
  always @(negedge clk) begin
    if (hs_seen) begin
      exp_t e;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R7 actual=unexpected_handshake expected=none");
      end else begin
        e = exp_q.pop_front();
        check("R8 drop pulse", 32'(pkt_drop), 32'(e.drop));
        check("R7/R9 avail", host_rdata, 32'(e.avail));
        check("R11 wr_ptr", 32'(wr_ptr), 32'(e.ptr));
        check("R2 has_pkt", 32'(rx_has_pkt), 32'(e.has));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    host_read("R1 ctrl", 2'd0, 32'h0);
    host_read("R1 avail", 2'd3, 32'h0);
    host_read("R1 size", 2'd2, 32'h0);
    check("R1 drop", 32'(pkt_drop), 0);
    check("R1 wr_ptr", 32'(wr_ptr), 0);
    // R6 disabled: offer held, nothing moves
    @(negedge clk);
    pkt_valid = 1'b1; pkt_words = 16'd3;
    repeat (3) @(negedge clk);
    check("R6 ready low", 32'(pkt_ready), 0);
    pkt_valid = 1'b0;
    host_read("R6 avail unchanged", 2'd3, 32'h0);
    // R4/R3 program base and size
    m_base = 'h1000; m_size = 64; m_ptr = m_base; m_avail = 64;
    host_write(2'd1, 32'h1000);
    host_write(2'd2, 32'd64);
    host_read("R3 size read", 2'd2, 32'd64);
    host_read("R3 avail reload", 2'd3, 32'd64);
    check("R4 ptr at base", 32'(wr_ptr), 32'h1000);
    // R2 control fields
    host_write(2'd0, 32'h00A5_0001);
    host_read("R2 ctrl read", 2'd0, 32'h00A5_0001);
    check("R2 mask pin", 32'(class_mask), 32'hA5);
    check("R6 ready follows enable", 32'(pkt_ready), 1);
    // R7 commits, R8 drop, R7 exact fit, R11 wrap at end
    send_pkt(10, 0);
    host_read("R4 last descriptor", 2'd1, 32'h1000);
    send_pkt(30, 0);
    send_pkt(20, 0);
    send_pkt(18, 0);
    host_read("R4 last descriptor after wrap", 2'd1, 32'h102C);
    check("R11 wrapped to base", 32'(wr_ptr), 32'h1000);
    // R5 return adds
    host_return(44);
    host_read("R5 additive return", 2'd3, 32'(m_avail));
    // R9 return and commit together
    send_pkt(4, 8);
    // R10 return to full clears flag
    host_return(18);
    host_read("R10 avail full", 2'd3, 32'd64);
    check("R10 has_pkt cleared", 32'(rx_has_pkt), 0);
    // R5 saturation
    host_return(10);
    host_read("R5 saturate", 2'd3, 32'd64);
    // R3 size reload resets pointer and flag
    send_pkt(1, 0);
    host_write(2'd2, 32'd64);
    m_ptr = m_base; m_avail = 64; m_has = 1'b0;
    check("R3 ptr reset", 32'(wr_ptr), 32'h1000);
    check("R3 flag cleared", 32'(rx_has_pkt), 0);
    repeat (3) @(negedge clk);
    check("queue drained", 32'(exp_q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule